// File: doc/BRIEF.md
# Fractional-N Clock Divider

This block derives a slower clock from the source clock at an average ratio of N + b/a. It does this without an accumulator. It places periods of n source cycles and periods of n+1 source cycles in a fixed nested pattern. Four pattern parameters describe that pattern: a repeat count z, an inner run length x, a tail length y, and a flag (long-rich) that selects one of the two pattern shapes. Software works these values out from a and b and presents them on the inputs together with the integer divisor n.

Every output period starts with a one-cycle strobe. The divided clock is high for the first floor(L/2) cycles of a period of L cycles and low for the rest. The configuration is sampled while the enable is low, and again at the start of each new pattern. A change made part way through a pattern therefore never cuts a period short and never mixes two patterns. Pulling the enable low stops the output. The next rising edge of the enable starts a fresh pattern.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is high, `div_clk` and `div_stb` are 0. The internal configuration resets to n=2, x=0, y=1, z=0. If `clk_active` is already high when reset is released, the first output period therefore lasts 2 cycles. Values on the configuration inputs take effect from the second period.
- R2: With `pat_z` = 0, every output period is `div_int` cycles long, whatever `pat_x`, `pat_y` and `pat_long` hold.
- R3: An output period of L cycles has `div_clk` high for floor(L/2) cycles, starting in the strobe cycle, and low for the remaining cycles.
- R4: With `pat_long` = 0 and z > 0, one pattern is z repeats of (x periods of n, then one period of n+1), followed by y periods of n. The pattern then restarts.
- R5: With `pat_long` = 1 and z > 0, one pattern is z repeats of (one period of n, then x periods of n+1), followed by y periods of n+1.
- R6: With parameters computed from a and b, one pattern holds a−b periods of n and b periods of n+1. Its total length is a·n + b source cycles.
- R7: With y = 0 and z > 0, the pattern ends right after the last group and restarts with no tail periods.
- R8: Configuration inputs are sampled only while `clk_active` is low and when the last period of a pattern begins. A change made during a pattern is first seen in the period that follows that pattern.
- R9: One clock after `clk_active` falls, both outputs are 0, and they stay 0 while it stays low. After it rises again, output restarts at the first period of a new pattern built from the current inputs.
- R10: A divisor below 2 (0 or 1) is treated as 2.
- R11: `div_stb` is high for exactly one cycle at the start of each period. It is never high in two consecutive cycles, and `div_clk` is high whenever `div_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_active | input | 1 | Output enable; low stops the output and rearms the pattern |
| div_int | input | 8 | Integer divisor n |
| pat_x | input | 9 | Inner run length x of each group |
| pat_y | input | 9 | Number of tail periods y |
| pat_z | input | 9 | Number of group repeats z; 0 selects plain divide-by-n |
| pat_long | input | 1 | Pattern shape: 0 when b ≤ a/2, 1 when b > a/2 |
| div_clk | output | 1 | Divided clock, registered |
| div_stb | output | 1 | One-cycle strobe at the start of each output period, registered |

## Verification
The in-line assertions check the cycle-level invariants on every cycle: the strobe is a single cycle and always falls in a high cycle, both outputs are quiet one cycle after the enable drops, loaded period lengths never fall below 2, the period counter stays inside its period, and the latched configuration holds still between pattern boundaries. The scenarios alone can show the sequences themselves. These are the ordering of short and long periods for both pattern shapes, the missing tail when y is zero, the count balance of n and n+1 periods, and the point where a change made mid-pattern takes effect. They also cover the default configuration that shapes the first period after reset, and the restart from the top of a pattern after the enable is toggled.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  // Width of the integer divisor and of each pattern parameter
  parameter int unsigned DIV_W = 8;
  parameter int unsigned PAT_W = 9;
  // Period lengths reach n+1, so they need one extra bit
  localparam int unsigned LEN_W = DIV_W + 1;

  typedef enum logic [0:0] {
    PH_GROUP = 1'b0,
    PH_TAIL  = 1'b1
  } phase_e;

  typedef struct packed {
    logic [DIV_W-1:0] n;
    logic [PAT_W-1:0] x;
    logic [PAT_W-1:0] y;
    logic [PAT_W-1:0] z;
    logic             long_rich;
  } frac_cfg_t;

endpackage

// File: rtl/frac_div_seq.sv
// Pattern sequencer: holds the latched configuration and the position in
// the nested pattern, and reports the length of the period at that position.
module frac_div_seq
  import frac_div_pkg::*;
#(
  parameter frac_cfg_t RST_CFG = '{n: 8'd2, x: 9'd0, y: 9'd1, z: 9'd0, long_rich: 1'b0}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             take,
  input  frac_cfg_t        cfg_in,
  output logic [LEN_W-1:0] per_len
);

  frac_cfg_t        cfg_q;
  phase_e           phase_q;
  logic [PAT_W-1:0] grp_q;
  logic [PAT_W-1:0] sub_q;
  logic [PAT_W-1:0] tail_q;

  logic [LEN_W-1:0] len_short;
  logic [LEN_W-1:0] len_long;
  logic             plain;
  logic             sub_end;
  logic             grp_end;
  logic             last;

  // Divisors below 2 are raised to 2 (R10)
  always_comb begin
    if (cfg_q.n < DIV_W'(2)) len_short = LEN_W'(2);
    else                     len_short = {1'b0, cfg_q.n};
    len_long = len_short + LEN_W'(1);
  end

  assign plain   = (cfg_q.z == '0);
  assign sub_end = (sub_q == cfg_q.x);
  assign grp_end = (grp_q == cfg_q.z - PAT_W'(1));

  // The current position is the final period of the pattern
  always_comb begin
    if (plain)                    last = 1'b1;
    else if (phase_q == PH_TAIL)  last = (tail_q == cfg_q.y - PAT_W'(1));
    else                          last = sub_end && grp_end && (cfg_q.y == '0);
  end

  // Length of the period at the current position
  always_comb begin
    if (plain) begin
      per_len = len_short;
    end else if (phase_q == PH_TAIL) begin
      per_len = cfg_q.long_rich ? len_long : len_short;
    end else if (cfg_q.long_rich) begin
      per_len = (sub_q == '0) ? len_short : len_long;
    end else begin
      per_len = sub_end ? len_long : len_short;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= RST_CFG;
      phase_q <= PH_GROUP;
      grp_q   <= '0;
      sub_q   <= '0;
      tail_q  <= '0;
    end else if (!active || (take && last)) begin
      cfg_q   <= cfg_in;
      phase_q <= PH_GROUP;
      grp_q   <= '0;
      sub_q   <= '0;
      tail_q  <= '0;
    end else if (take) begin
      if (phase_q == PH_TAIL) begin
        tail_q <= tail_q + PAT_W'(1);
      end else if (!sub_end) begin
        sub_q <= sub_q + PAT_W'(1);
      end else begin
        sub_q <= '0;
        if (!grp_end) begin
          grp_q <= grp_q + PAT_W'(1);
        end else begin
          phase_q <= PH_TAIL;
          tail_q  <= '0;
        end
      end
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !(take && last)) |=> $stable(cfg_q));

  // R4
  pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !plain && phase_q == PH_GROUP) |-> (sub_q <= cfg_q.x && grp_q < cfg_q.z));

  // R7
  tail_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !plain && phase_q == PH_TAIL) |-> (tail_q < cfg_q.y));

endmodule

// File: rtl/frac_div_wave.sv
// Waveform generator: counts source cycles inside the current period,
// asks the sequencer for the next length, and drives registered outputs.
module frac_div_wave
  import frac_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [LEN_W-1:0] per_len,
  output logic             take,
  output logic             div_clk,
  output logic             div_stb
);

  logic             running_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_nx;

  assign take   = active && (!running_q || (cnt_q == len_q - LEN_W'(1)));
  assign cnt_nx = cnt_q + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      len_q     <= LEN_W'(2);
      div_clk   <= 1'b0;
      div_stb   <= 1'b0;
    end else if (take) begin
      running_q <= 1'b1;
      cnt_q     <= '0;
      len_q     <= per_len;
      div_clk   <= 1'b1;
      div_stb   <= 1'b1;
    end else begin
      cnt_q     <= cnt_nx;
      div_clk   <= (cnt_nx < (len_q >> 1));
      div_stb   <= 1'b0;
    end
  end

  // R11
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    div_stb |=> !div_stb);

  // R11
  stb_high_chk: assert property (@(posedge clk) disable iff (rst)
    div_stb |-> div_clk);

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!div_clk && !div_stb));

  // R10
  len_min_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> (per_len >= LEN_W'(2)));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    running_q |-> (cnt_q < len_q));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int unsigned DEF_N = 2,
  parameter int unsigned DEF_X = 0,
  parameter int unsigned DEF_Y = 1,
  parameter int unsigned DEF_Z = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_active,
  input  logic [DIV_W-1:0] div_int,
  input  logic [PAT_W-1:0] pat_x,
  input  logic [PAT_W-1:0] pat_y,
  input  logic [PAT_W-1:0] pat_z,
  input  logic             pat_long,
  output logic             div_clk,
  output logic             div_stb
);

  localparam frac_cfg_t RST_CFG = '{
    n:         DIV_W'(DEF_N),
    x:         PAT_W'(DEF_X),
    y:         PAT_W'(DEF_Y),
    z:         PAT_W'(DEF_Z),
    long_rich: 1'b0
  };

  frac_cfg_t        cfg_in;
  logic [LEN_W-1:0] per_len;
  logic             take;

  assign cfg_in = '{n: div_int, x: pat_x, y: pat_y, z: pat_z, long_rich: pat_long};

  frac_div_seq #(
    .RST_CFG (RST_CFG)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .active  (clk_active),
    .take    (take),
    .cfg_in  (cfg_in),
    .per_len (per_len)
  );

  frac_div_wave u_wave (
    .clk     (clk),
    .rst     (rst),
    .active  (clk_active),
    .per_len (per_len),
    .take    (take),
    .div_clk (div_clk),
    .div_stb (div_stb)
  );

endmodule

// File: tb/sim_frac_clk_div.sv
`timescale 1ns/1ps
module sim_frac_clk_div;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_active = 1'b0;
  logic [7:0] div_int = 8'd2;
  logic [8:0] pat_x = '0;
  logic [8:0] pat_y = '0;
  logic [8:0] pat_z = '0;
  logic       pat_long = 1'b0;
  logic       div_clk;
  logic       div_stb;

  always #4 clk = ~clk;

  frac_clk_div u0 (
    .clk        (clk),
    .rst        (rst),
    .clk_active (clk_active),
    .div_int    (div_int),
    .pat_x      (pat_x),
    .pat_y      (pat_y),
    .pat_z      (pat_z),
    .pat_long   (pat_long),
    .div_clk    (div_clk),
    .div_stb    (div_stb)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit wd_fired = 1'b0;

  // capture of completed periods
  bit cap_on   = 1'b0;
  bit have_prev = 1'b0;
  int prev_stb = 0;
  int hcnt     = 0;
  int cap_len[$];
  int cap_high[$];
  int exp_q[$];

  task automatic check(input string req, input string what, input int got, input int expv);
    n_checks++;
    if (got != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cap_on) begin
      if (div_stb) begin
        // R11: strobe falls in a high cycle
        check("R11", "div_clk during strobe", int'(div_clk), 1);
        if (have_prev) begin
          cap_len.push_back(cyc - prev_stb);
          cap_high.push_back(hcnt);
        end
        have_prev = 1'b1;
        prev_stb  = cyc;
        hcnt      = 0;
      end
      if (div_clk) hcnt++;
    end
    if (cyc > 150000 && !wd_fired) begin
      wd_fired = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic clear_cap();
    cap_on    = 1'b1;
    have_prev = 1'b0;
    hcnt      = 0;
    cap_len.delete();
    cap_high.delete();
  endtask

  task automatic wait_periods(input string req, input int k);
    int t = 0;
    while (cap_len.size() < k && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(req, "periods captured", (cap_len.size() >= k) ? k : cap_len.size(), k);
  endtask

  // expected period lengths from the pattern rules (R2, R4, R5, R7, R10)
  task automatic push_pattern(input int n, input int x, input int y, input int z,
                              input bit lr, input int reps);
    int ns = (n < 2) ? 2 : n;
    for (int r = 0; r < reps; r++) begin
      if (z == 0) begin
        exp_q.push_back(ns);
      end else begin
        for (int g = 0; g < z; g++) begin
          if (lr) begin
            exp_q.push_back(ns);
            for (int i = 0; i < x; i++) exp_q.push_back(ns + 1);
          end else begin
            for (int i = 0; i < x; i++) exp_q.push_back(ns);
            exp_q.push_back(ns + 1);
          end
        end
        for (int i = 0; i < y; i++) exp_q.push_back(lr ? ns + 1 : ns);
      end
    end
  endtask

  task automatic compare_exp(input string req);
    wait_periods(req, exp_q.size());
    for (int i = 0; i < exp_q.size() && i < cap_len.size(); i++) begin
      check(req, $sformatf("period %0d length", i), cap_len[i], exp_q[i]);
      // R3: high phase is floor(L/2)
      check("R3", $sformatf("period %0d high cycles", i), cap_high[i], exp_q[i] / 2);
    end
  endtask

  task automatic start_cfg(input int n, input int x, input int y, input int z, input bit lr);
    @(negedge clk);
    clk_active = 1'b0;
    div_int  = 8'(n);
    pat_x    = 9'(x);
    pat_y    = 9'(y);
    pat_z    = 9'(z);
    pat_long = lr;
    repeat (2) @(negedge clk);
    clear_cap();
    exp_q.delete();
    clk_active = 1'b1;
  endtask

  // R1: reset state and default first period
  task automatic t_reset();
    div_int = 8'd5; pat_z = '0; clk_active = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "div_clk in reset", int'(div_clk), 0);
    check("R1", "div_stb in reset", int'(div_stb), 0);
    clear_cap();
    rst = 1'b0;
    exp_q.delete();
    exp_q.push_back(2);
    push_pattern(5, 0, 0, 0, 1'b0, 3);
    compare_exp("R1");
  endtask

  // R2: plain integer division, inner/tail values ignored
  task automatic t_plain();
    start_cfg(5, 4, 3, 0, 1'b0);
    push_pattern(5, 4, 3, 0, 1'b0, 4);
    compare_exp("R2");
    start_cfg(7, 0, 0, 0, 1'b1);
    push_pattern(7, 0, 0, 0, 1'b1, 3);
    compare_exp("R2");
  endtask

  // R4 and R6: a=7 b=3 -> z=3 y=1 x=1, short-rich shape
  task automatic t_short_rich();
    int nshort = 0, nlong = 0, tot = 0;
    start_cfg(4, 1, 1, 3, 1'b0);
    push_pattern(4, 1, 1, 3, 1'b0, 2);
    compare_exp("R4");
    for (int i = 0; i < 7 && i < cap_len.size(); i++) begin
      if (cap_len[i] == 4) nshort++;
      if (cap_len[i] == 5) nlong++;
      tot += cap_len[i];
    end
    check("R6", "short periods (a-b)", nshort, 4);
    check("R6", "long periods (b)", nlong, 3);
    check("R6", "pattern cycles a*n+b", tot, 7 * 4 + 3);
  endtask

  // R5 and R6: a=5 b=3 -> z=2 y=1 x=1, long-rich shape
  task automatic t_long_rich();
    int nshort = 0, nlong = 0, tot = 0;
    start_cfg(3, 1, 1, 2, 1'b1);
    push_pattern(3, 1, 1, 2, 1'b1, 2);
    compare_exp("R5");
    for (int i = 0; i < 5 && i < cap_len.size(); i++) begin
      if (cap_len[i] == 3) nshort++;
      if (cap_len[i] == 4) nlong++;
      tot += cap_len[i];
    end
    check("R6", "short periods (a-b)", nshort, 2);
    check("R6", "long periods (b)", nlong, 3);
    check("R6", "pattern cycles a*n+b", tot, 5 * 3 + 3);
  endtask

  // R7: no tail (a=4 b=2 -> z=2 y=0 x=1)
  task automatic t_no_tail();
    start_cfg(5, 1, 0, 2, 1'b0);
    push_pattern(5, 1, 0, 2, 1'b0, 3);
    compare_exp("R7");
  endtask

  // R8: mid-pattern change waits for the pattern end
  task automatic t_change();
    start_cfg(4, 1, 1, 3, 1'b0);
    wait_periods("R8", 2);
    div_int = 8'd6; pat_z = '0; pat_x = '0; pat_y = '0;
    push_pattern(4, 1, 1, 3, 1'b0, 1);
    push_pattern(6, 0, 0, 0, 1'b0, 3);
    compare_exp("R8");
  endtask

  // R9: gating low silences output, re-enable restarts pattern
  task automatic t_gate();
    int bad = 0;
    start_cfg(4, 0, 0, 0, 1'b0);
    wait_periods("R9", 3);
    clk_active = 1'b0;
    cap_on = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (div_clk || div_stb) bad++;
    end
    check("R9", "active output cycles while gated", bad, 0);
    start_cfg(4, 0, 1, 1, 1'b1);
    push_pattern(4, 0, 1, 1, 1'b1, 3);
    compare_exp("R9");
  endtask

  // R10: divisor below 2
  task automatic t_min_div();
    start_cfg(1, 0, 0, 0, 1'b0);
    push_pattern(1, 0, 0, 0, 1'b0, 3);
    compare_exp("R10");
    start_cfg(0, 0, 0, 0, 1'b0);
    push_pattern(0, 0, 0, 0, 1'b0, 3);
    compare_exp("R10");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_short_rich();
    t_long_rich();
    t_no_tail();
    t_change();
    t_gate();
    t_min_div();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule